// File: doc/BRIEF.md
# Writeback-Slot Result Shift Register

This block keeps results leaving a pipeline in program order when its functional units take different numbers of cycles. It keeps a short window of future writeback cycles as a row of slots. Slot 0 is the writeback of the current cycle, and slot k is the writeback k cycles from now. Every clock the whole row moves one place toward slot 0.

An instruction asks to issue by giving its latency, the unit that will run it, its destination register and its PC. It may issue only if slots 1 through L (its latency) are all empty. When it does, it claims every one of those slots. Only the slot for its completion cycle holds its unit, destination and PC. The slots before it hold an occupancy bit only. When that record reaches slot 0, it is presented on the writeback outputs for exactly one cycle.

Because an instruction must find every slot up to its own completion free, no later instruction can complete before an earlier one. A flush input drops all reservations in one cycle. A latency of zero, or a latency beyond the longest supported one, is refused with an error indication.

Top module: `wbs_result_shreg`

## Requirements
- R1: After reset the writeback output is idle and every slot is free, so a request with latency MAX_LAT is granted in the first cycle after reset.
- R2: A request whose latency is 0 or greater than MAX_LAT raises iss_err in the same cycle, with iss_grant and iss_stall low, and claims no slot.
- R3: A request with latency L in 1..MAX_LAT is granted in the same cycle (iss_grant high) when slots 1..L are all free and flush is low.
- R4: A request with legal latency stalls (iss_stall high, iss_grant low, nothing claimed) while any of slots 1..L is occupied. Example: a latency-6 issue blocks a latency-3 request for the next 5 cycles, and that request is granted on its 6th attempt.
- R5: An instruction granted in cycle t with latency L appears on the outputs in cycle t+L: wb_valid is high and wb_unit, wb_dst and wb_pc carry its request fields. wb_valid is high for that one cycle only.
- R6: The slots move one position toward the head each cycle. Slots that an instruction claimed before its completion slot block issue but never produce a writeback.
- R7: Writebacks leave in the same order as the grants that created them.
- R8: When flush is high in a cycle, no request is granted in that cycle (a legal request reports iss_stall). From the next cycle on, no reservation made before the flush produces a writeback or blocks issue.
- R9: While wb_valid is low, wb_unit, wb_dst and wb_pc are all zero.
- R10: iss_grant, iss_stall and iss_err are never high together, and all three are low when iss_req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop all reservations at the next edge; blocks issue in this cycle |
| iss_req | input | 1 | Issue request |
| iss_lat | input | LAT_W ($clog2(MAX_LAT+1)+1) | Requested latency in cycles |
| iss_unit | input | UNIT_W (3) | Functional unit identifier |
| iss_dst | input | REG_W (5) | Destination register |
| iss_pc | input | PC_W (32) | Instruction PC |
| iss_grant | output | 1 | Request accepted this cycle |
| iss_stall | output | 1 | Legal request held back this cycle |
| iss_err | output | 1 | Request refused for an illegal latency |
| wb_valid | output | 1 | A completion record is at the head this cycle |
| wb_unit | output | UNIT_W (3) | Unit of the completing instruction |
| wb_dst | output | REG_W (5) | Destination of the completing instruction |
| wb_pc | output | PC_W (32) | PC of the completing instruction |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a grant and a writeback. When the head shows the last pending record, the window beyond it is already empty, so a new request must be granted in that cycle while the old record is still on the outputs. Back-to-back latency-1 issues and the latency-6/latency-3 pair provoke this. The second pair is flush and issue: the bench holds a legal request while it asserts flush, and expects a stall in that cycle and a free window in the cycle after. A behavioural model in the bench keeps pending completions as a queue with absolute due cycles. It predicts the grant, stall and error outcome and the head record in every cycle. A directed phase and a pseudo-random phase are both compared against it.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    localparam int UNIT_W = 3;
    localparam int REG_W  = 5;
    localparam int PC_W   = 32;

    typedef logic [UNIT_W-1:0] unit_t;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [PC_W-1:0]   pc_t;

    // completion record carried by an issuing instruction
    typedef struct packed {
        unit_t unit;
        reg_t  dst;
        pc_t   pc;
    } rec_t;

    // one writeback slot: occupancy plus, at the completion slot, the record
    typedef struct packed {
        logic  occ;
        logic  fin;
        unit_t unit;
        reg_t  dst;
        pc_t   pc;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '0;

    function automatic slot_t make_final(input rec_t r);
        slot_t s;
        s      = SLOT_EMPTY;
        s.occ  = 1'b1;
        s.fin  = 1'b1;
        s.unit = r.unit;
        s.dst  = r.dst;
        s.pc   = r.pc;
        return s;
    endfunction

endpackage

// File: rtl/wbs_issue_ctl.sv
module wbs_issue_ctl
    import wbs_pkg::*;
#(
    parameter int MAX_LAT = 7,
    parameter int DEPTH   = MAX_LAT + 1,
    parameter int LAT_W   = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             iss_req,
    input  logic [LAT_W-1:0] iss_lat,
    input  logic [DEPTH-1:0] occ_vec,
    output logic             iss_grant,
    output logic             iss_stall,
    output logic             iss_err
);

    logic [DEPTH-1:0] hit;
    logic             lat_bad;
    logic             busy;

    assign hit[0] = 1'b0;

    // window of slots 1..L that the request would claim
    generate
        for (genvar k = 1; k < DEPTH; k++) begin : g_win
            assign hit[k] = occ_vec[k] && (LAT_W'(k) <= iss_lat);
        end
    endgenerate

    assign lat_bad   = (iss_lat == '0) || (iss_lat > LAT_W'(MAX_LAT));
    assign busy      = |hit;
    assign iss_err   = iss_req && lat_bad;
    assign iss_grant = iss_req && !lat_bad && !busy && !flush;
    assign iss_stall = iss_req && !lat_bad && (busy || flush);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({iss_grant, iss_stall, iss_err})) else $error("outcome overlap"); // R10

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !iss_req |-> !(iss_grant || iss_stall || iss_err)) else $error("outcome without request"); // R10

endmodule

// File: rtl/wbs_slot_ring.sv
module wbs_slot_ring
    import wbs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             claim,
    input  logic [LAT_W-1:0] claim_lat,
    input  rec_t             claim_rec,
    output logic [DEPTH-1:0] occ_vec,
    output slot_t            head
);

    slot_t [DEPTH-1:0] slots;
    slot_t [DEPTH-1:0] nxt;

    always_comb begin
        // advance one position toward the head
        for (int j = 0; j < DEPTH - 1; j++) begin
            nxt[j] = slots[j + 1];
        end
        nxt[DEPTH-1] = SLOT_EMPTY;
        // claimed slots land one place lower after the shift
        if (claim) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (j == int'(claim_lat) - 1) begin
                    nxt[j] = make_final(claim_rec);
                end else if (j < int'(claim_lat)) begin
                    nxt[j].occ = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            slots <= '0;
        end else begin
            slots <= nxt;
        end
    end

    generate
        for (genvar j = 0; j < DEPTH; j++) begin : g_occ
            assign occ_vec[j] = slots[j].occ;
        end
    endgenerate

    assign head = slots[0];

    AST_CLAIM_INTO_FREE: assert property (@(posedge clk) disable iff (rst)
        claim |-> !occ_vec[1]) else $error("claim over occupied slot"); // R4

    AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(flush) && !$past(claim)) |-> (slots[0] == $past(slots[1])))
        else $error("slot row did not advance"); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occ_vec == '0)) else $error("flush left reservations"); // R8

endmodule

// File: rtl/wbs_head_out.sv
module wbs_head_out
    import wbs_pkg::*;
(
    input  slot_t head,
    output logic  wb_valid,
    output unit_t wb_unit,
    output reg_t  wb_dst,
    output pc_t   wb_pc
);

    always_comb begin
        wb_valid = head.fin;
        wb_unit  = '0;
        wb_dst   = '0;
        wb_pc    = '0;
        if (head.fin) begin
            wb_unit = head.unit;
            wb_dst  = head.dst;
            wb_pc   = head.pc;
        end
    end

endmodule

// File: rtl/wbs_result_shreg.sv
module wbs_result_shreg
    import wbs_pkg::*;
#(
    parameter  int MAX_LAT = 7,
    localparam int DEPTH   = MAX_LAT + 1,
    localparam int LAT_W   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              iss_req,
    input  logic [LAT_W-1:0]  iss_lat,
    input  logic [UNIT_W-1:0] iss_unit,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [PC_W-1:0]   iss_pc,
    output logic              iss_grant,
    output logic              iss_stall,
    output logic              iss_err,
    output logic              wb_valid,
    output logic [UNIT_W-1:0] wb_unit,
    output logic [REG_W-1:0]  wb_dst,
    output logic [PC_W-1:0]   wb_pc
);

    logic [DEPTH-1:0] occ_vec;
    slot_t            head;
    rec_t             req_rec;

    assign req_rec = '{unit: iss_unit, dst: iss_dst, pc: iss_pc};

    wbs_issue_ctl #(
        .MAX_LAT (MAX_LAT),
        .DEPTH   (DEPTH),
        .LAT_W   (LAT_W)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .iss_req   (iss_req),
        .iss_lat   (iss_lat),
        .occ_vec   (occ_vec),
        .iss_grant (iss_grant),
        .iss_stall (iss_stall),
        .iss_err   (iss_err)
    );

    wbs_slot_ring #(
        .DEPTH (DEPTH),
        .LAT_W (LAT_W)
    ) u_ring (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .claim     (iss_grant),
        .claim_lat (iss_lat),
        .claim_rec (req_rec),
        .occ_vec   (occ_vec),
        .head      (head)
    );

    wbs_head_out u_head (
        .head     (head),
        .wb_valid (wb_valid),
        .wb_unit  (wb_unit),
        .wb_dst   (wb_dst),
        .wb_pc    (wb_pc)
    );

    AST_LAT1_LANDS: assert property (@(posedge clk) disable iff (rst)
        (iss_grant && iss_lat == LAT_W'(1) && !flush) |=>
            (wb_valid && wb_dst == $past(iss_dst) && wb_pc == $past(iss_pc)))
        else $error("latency-1 result missing"); // R5

    AST_QUIET_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush |=> !wb_valid) else $error("writeback after flush"); // R8

    AST_BAD_LAT_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (iss_req && (iss_lat == '0)) |-> (iss_err && !iss_grant)) else $error("zero latency accepted"); // R2

endmodule

// File: tb/wbs_result_shreg_tb_top.sv
module wbs_result_shreg_tb_top;

    localparam int MAX_LAT = 7;
    localparam int LAT_W   = $clog2(MAX_LAT + 1) + 1;

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic        iss_req;
    logic [LAT_W-1:0] iss_lat;
    logic [2:0]  iss_unit;
    logic [4:0]  iss_dst;
    logic [31:0] iss_pc;
    logic        iss_grant, iss_stall, iss_err;
    logic        wb_valid;
    logic [2:0]  wb_unit;
    logic [4:0]  wb_dst;
    logic [31:0] wb_pc;

    always #5 clk = ~clk;

    wbs_result_shreg #(.MAX_LAT(MAX_LAT)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .iss_req(iss_req), .iss_lat(iss_lat), .iss_unit(iss_unit),
        .iss_dst(iss_dst), .iss_pc(iss_pc),
        .iss_grant(iss_grant), .iss_stall(iss_stall), .iss_err(iss_err),
        .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_dst(wb_dst), .wb_pc(wb_pc)
    );

    typedef struct {
        int          due;
        int          unit;
        int          dst;
        logic [31:0] pc;
    } pend_t;

    pend_t       pend_q[$];
    logic [31:0] grant_order[$];
    logic [31:0] wb_order[$];
    int  now;
    int  busy_until;
    bit  after_flush;
    bit  last_grant;
    int  n_chk;
    int  n_fail;
    bit  finished;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, now, act, exp);
        end
    endtask

    task automatic step(input bit req, input int lat, input int unit, input int dst,
                        input logic [31:0] pc, input bit fl, input string force_tag);
        bit eg, es, ee, bad, ev;
        logic [39:0] ewb;
        string t;
        @(negedge clk);
        iss_req  = req;
        iss_lat  = LAT_W'(lat);
        iss_unit = 3'(unit);
        iss_dst  = 5'(dst);
        iss_pc   = pc;
        flush    = fl;
        #1;
        bad = (lat == 0) || (lat > MAX_LAT);
        ee  = req && bad;
        eg  = req && !bad && !fl && (busy_until <= now);
        es  = req && !bad && !eg;
        t = ee ? "R2" : eg ? "R3" : es ? (fl ? "R8" : "R4") : "R10";
        if (force_tag != "") t = force_tag;
        chk({iss_grant, iss_stall, iss_err} == {eg, es, ee}, t, "grant/stall/err",
            64'({iss_grant, iss_stall, iss_err}), 64'({eg, es, ee}));
        ev  = (pend_q.size() > 0) && (pend_q[0].due == now);
        ewb = ev ? {3'(pend_q[0].unit), 5'(pend_q[0].dst), pend_q[0].pc} : 40'd0;
        t = ev ? "R5" : after_flush ? "R8" : (busy_until > now) ? "R6" : "R9";
        if (force_tag != "") t = force_tag;
        chk((wb_valid == ev) && ({wb_unit, wb_dst, wb_pc} == ewb), t, "head valid/unit/dst/pc",
            64'({wb_valid, wb_unit, wb_dst, wb_pc}), 64'({ev, ewb}));
        if (wb_valid) wb_order.push_back(wb_pc);
        if (ev) void'(pend_q.pop_front());
        if (fl) begin
            pend_q.delete();
            busy_until = now;
        end else if (eg) begin
            pend_q.push_back('{due: now + lat, unit: unit, dst: dst, pc: pc});
            busy_until = now + lat;
            grant_order.push_back(pc);
        end
        after_flush = fl;
        last_grant  = eg;
        now++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0, 32'h0, 0, "");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        int          tries;
        n_chk = 0; n_fail = 0; finished = 1'b0;
        now = 0; busy_until = 0; after_flush = 0; last_grant = 0;
        rst = 1'b1; flush = 0; iss_req = 0; iss_lat = '0;
        iss_unit = '0; iss_dst = '0; iss_pc = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: idle head after reset, full window free
        step(0, 1, 0, 0, 32'h0, 0, "R1");
        step(1, MAX_LAT, 5, 17, 32'h0000_1000, 0, "R1");
        idle(MAX_LAT + 1);

        // R3/R5: back-to-back latency-1 issues, grant coincides with writeback
        for (int i = 0; i < 6; i++) step(1, 1, i, i + 1, 32'h2000 + 32'(i), 0, "");
        idle(2);

        // R4: latency 6 then latency 3 held until the 6th attempt
        step(1, 6, 2, 8, 32'h3000, 0, "");
        tries = 0;
        for (int i = 0; i < 10; i++) begin
            step(1, 3, 1, 9, 32'h3004, 0, "");
            tries++;
            if (last_grant) break;
        end
        chk(tries == 6, "R4", "attempts until grant", 64'(tries), 64'd6);
        idle(5);

        // R2: illegal latencies
        step(1, 0, 3, 3, 32'h4000, 0, "");
        step(1, MAX_LAT + 1, 3, 3, 32'h4004, 0, "");
        step(1, 15, 3, 3, 32'h4008, 0, "");
        idle(MAX_LAT + 1);

        // R8: flush drops pending work, and blocks issue in its own cycle
        step(1, 5, 4, 12, 32'h5000, 0, "");
        idle(2);
        step(1, 2, 4, 13, 32'h5004, 1, "");
        step(1, 2, 4, 14, 32'h5008, 0, "");
        idle(MAX_LAT + 1);

        // R6/R7: pseudo-random mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], int'(lfsr[4:1]) % (MAX_LAT + 3), int'(lfsr[7:5]), int'(lfsr[12:8]),
                 32'h8000 + 32'(i), (lfsr[15:11] == 5'd7), "");
        end
        idle(MAX_LAT + 2);

        // R7: order of writebacks matches order of surviving grants
        begin
            int m;
            m = 0;
            for (int i = 0; i < grant_order.size(); i++) begin
                if (m < wb_order.size() && wb_order[m] == grant_order[i]) m++;
            end
            chk(m == wb_order.size(), "R7", "writebacks in grant order",
                64'(m), 64'(wb_order.size()));
        end
        summary();
    end

endmodule